// File: doc/BRIEF.md
# Dual-Lane NOR Flash Array Model

This block is a synthesizable stand-in for a 32-bit NOR flash array made of two 16-bit devices placed side by side on one bus. Each 32-bit access reaches both devices at once. The low half-word goes to lane 0 and the high half-word goes to lane 1. Each lane runs its own command engine, status byte, busy timer and per-block lock bits. A driver that sends the same command code in both halves controls the two devices together. Sending a different code in each half drives them separately.

A lane decodes one-cycle commands and two-cycle commands. The one-cycle commands select array reads or status reads, or clear the error flags. The two-cycle commands are word program, block erase and block lock/unlock. A program can only turn bits from 1 to 0. An erase returns a whole block to all ones. Program and erase on a locked block leave the array untouched and raise error flags. Program, erase and lock/unlock each keep the lane busy for a parameterised number of cycles. During that time the ready flag reads 0 and all other writes to the lane are dropped.

Top module: `nor_pair_model`

## Requirements
- R1: After reset, every word reads 0xFFFF in both lanes, no block is locked, each lane is in array-read mode, and its status byte reads 0x80 (only the ready flag set).
- R2: Bits 15:0 of the bus are lane 0 and bits 31:16 are lane 1. Each lane decodes its command from the low byte of its own half-word and ignores the upper byte of a command. The two lanes never affect each other.
- R3: Read data is registered. It is valid in the cycle after the edge that samples `bus_re`, and it holds its value when `bus_re` is low. After code 0xFF a lane returns array words. After code 0x70 it returns {8'h00, status}.
- R4: Code 0x40 followed by a data write changes the addressed word to (old AND data) and puts the lane into status mode.
- R5: Code 0x20 followed by 0xD0 sets every word of the addressed block (2^BLK_SHIFT words, block number = upper address bits) to 0xFFFF and puts the lane into status mode.
- R6: Code 0x60 followed by 0x01 locks the addressed block. Code 0x60 followed by 0xD0 unlocks it.
- R7: A program on a locked block sets status bits 4 and 1. An erase on a locked block sets bits 5 and 1. In both cases the array is unchanged and the lane does not go busy.
- R8: The ready flag (status bit 7) reads 0 for exactly PROG_CYC, ERASE_CYC or LOCK_CYC cycles after the second write of the operation. While a lane is busy, its reads return status whatever the read mode, and writes to it are ignored.
- R9: Code 0x50 clears status bits 5, 4, 3 and 1 and leaves the read mode unchanged. Error bits persist until they are cleared this way.
- R10: If 0x20 or 0x60 is followed by a code that does not complete the sequence, the lane sets status bits 5 and 4 and changes nothing else except entering status mode.
- R11: First-cycle codes outside the supported set (for example 0x90, 0x98, 0xE8, 0xD0, 0x01) change neither the read mode nor the status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data, one half-word per lane |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |

## Verification
Read data appears one cycle after the edge that samples `bus_re`. The bench therefore samples `bus_rdata` 1 ns after that edge and compares it with a cycle-accurate reference. The reference is updated at the same edge, after the expected value has been taken from its pre-edge state. A busy window starts at the edge that accepts the second write. When the bench issues a status read every cycle from the next cycle on, the first N reads show ready low, and the bench counts those reads and compares the count with the parameter. Ignored writes, unsupported codes and locked-block errors are checked by reading status or array words in the cycles that follow.

// File: rtl/nor_pair_pkg.sv
package nor_pair_pkg;

    localparam int LANE_W = 16;

    localparam logic [7:0] CODE_ARRAY   = 8'hFF;
    localparam logic [7:0] CODE_STATUS  = 8'h70;
    localparam logic [7:0] CODE_CLEAR   = 8'h50;
    localparam logic [7:0] CODE_PROG    = 8'h40;
    localparam logic [7:0] CODE_ERASE   = 8'h20;
    localparam logic [7:0] CODE_LOCKSET = 8'h60;
    localparam logic [7:0] CODE_CONFIRM = 8'hD0;
    localparam logic [7:0] CODE_SETLOCK = 8'h01;
    localparam logic [7:0] CODE_IDENT   = 8'h90;
    localparam logic [7:0] CODE_QUERY   = 8'h98;
    localparam logic [7:0] CODE_BUFWR   = 8'hE8;

    // status byte bit positions
    localparam int ST_READY     = 7;
    localparam int ST_ERS_SUSP  = 6;
    localparam int ST_ERASE_ERR = 5;
    localparam int ST_PROG_ERR  = 4;
    localparam int ST_VOLT_ERR  = 3;
    localparam int ST_PRG_SUSP  = 2;
    localparam int ST_LOCKED    = 1;

    localparam logic [7:0] ST_CLEAR_MASK = 8'h3A;

    typedef enum logic {
        MODE_ARRAY  = 1'b0,
        MODE_STATUS = 1'b1
    } rd_mode_e;

    typedef enum logic [1:0] {
        PEND_NONE,
        PEND_PROG,
        PEND_ERASE,
        PEND_LOCK
    } pend_e;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_ARRAY,
        OP_STATUS,
        OP_CLEAR,
        OP_PROG,
        OP_ERASE,
        OP_LOCKSET,
        OP_CONFIRM,
        OP_SETLOCK,
        OP_IDENT,
        OP_QUERY,
        OP_BUFWR
    } op_e;

endpackage

// File: rtl/nor_cmd_decode.sv
module nor_cmd_decode
    import nor_pair_pkg::*;
(
    input  logic [7:0] code,
    output op_e        op
);
    always_comb begin
        unique case (code)
            CODE_ARRAY:   op = OP_ARRAY;
            CODE_STATUS:  op = OP_STATUS;
            CODE_CLEAR:   op = OP_CLEAR;
            CODE_PROG:    op = OP_PROG;
            CODE_ERASE:   op = OP_ERASE;
            CODE_LOCKSET: op = OP_LOCKSET;
            CODE_CONFIRM: op = OP_CONFIRM;
            CODE_SETLOCK: op = OP_SETLOCK;
            CODE_IDENT:   op = OP_IDENT;
            CODE_QUERY:   op = OP_QUERY;
            CODE_BUFWR:   op = OP_BUFWR;
            default:      op = OP_NONE;
        endcase
    end
endmodule

// File: rtl/nor_lane.sv
module nor_lane
    import nor_pair_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int BLK_SHIFT = 4,
    parameter int PROG_CYC  = 5,
    parameter int ERASE_CYC = 40,
    parameter int LOCK_CYC  = 3
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [ADDR_W-1:0]                     addr,
    input  logic [LANE_W-1:0]                     wdata,
    input  logic                                  we,
    input  logic                                  re,
    output logic [LANE_W-1:0]                     rdata,
    output logic                                  busy,
    output logic                                  erase_err,
    output logic [(1 << (ADDR_W-BLK_SHIFT))-1:0]  locks
);
    localparam int DEPTH   = 1 << ADDR_W;
    localparam int BLK_AW  = ADDR_W - BLK_SHIFT;
    localparam int NBLK    = 1 << BLK_AW;
    localparam int MAX_CYC = (ERASE_CYC > PROG_CYC)
                           ? ((ERASE_CYC > LOCK_CYC) ? ERASE_CYC : LOCK_CYC)
                           : ((PROG_CYC > LOCK_CYC) ? PROG_CYC : LOCK_CYC);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    typedef struct packed {
        logic [DEPTH-1:0][LANE_W-1:0] mem;
        logic [NBLK-1:0]              locks;
        logic [7:0]                   st;
        rd_mode_e                     mode;
        pend_e                        pend;
        logic [CNT_W-1:0]             cnt;
        logic [LANE_W-1:0]            rd;
    } lane_state_t;

    localparam lane_state_t RESET_S = '{
        mem:   '1,
        locks: '0,
        st:    '0,
        mode:  MODE_ARRAY,
        pend:  PEND_NONE,
        cnt:   '0,
        rd:    '0
    };

    lane_state_t q, d;
    op_e         op;
    logic [BLK_AW-1:0] blk;
    logic        busy_now;
    logic [LANE_W-1:0] view;

    nor_cmd_decode u_dec (
        .code (wdata[7:0]),
        .op   (op)
    );

    assign blk      = addr[ADDR_W-1:BLK_SHIFT];
    assign busy_now = (q.cnt != '0);

    always_comb begin
        if (q.mode == MODE_STATUS || busy_now) begin
            view = {8'h00, ~busy_now, q.st[6:0]};
        end else begin
            view = q.mem[addr];
        end
    end

    always_comb begin
        d = q;
        if (re) begin
            d.rd = view;
        end
        if (busy_now) begin
            d.cnt = q.cnt - 1'b1;
        end else if (we) begin
            unique case (q.pend)
                PEND_NONE: begin
                    unique case (op)
                        OP_ARRAY:   d.mode = MODE_ARRAY;
                        OP_STATUS:  d.mode = MODE_STATUS;
                        OP_CLEAR:   d.st   = q.st & ~ST_CLEAR_MASK;
                        OP_PROG:    d.pend = PEND_PROG;
                        OP_ERASE:   d.pend = PEND_ERASE;
                        OP_LOCKSET: d.pend = PEND_LOCK;
                        default:    ;
                    endcase
                end
                PEND_PROG: begin
                    d.pend = PEND_NONE;
                    d.mode = MODE_STATUS;
                    if (q.locks[blk]) begin
                        d.st[ST_PROG_ERR] = 1'b1;
                        d.st[ST_LOCKED]   = 1'b1;
                    end else begin
                        d.mem[addr] = q.mem[addr] & wdata;
                        d.cnt       = CNT_W'(PROG_CYC);
                    end
                end
                PEND_ERASE: begin
                    d.pend = PEND_NONE;
                    d.mode = MODE_STATUS;
                    if (op != OP_CONFIRM) begin
                        d.st[ST_ERASE_ERR] = 1'b1;
                        d.st[ST_PROG_ERR]  = 1'b1;
                    end else if (q.locks[blk]) begin
                        d.st[ST_ERASE_ERR] = 1'b1;
                        d.st[ST_LOCKED]    = 1'b1;
                    end else begin
                        for (int j = 0; j < DEPTH; j++) begin
                            if ((j >> BLK_SHIFT) == int'(blk)) begin
                                d.mem[j] = '1;
                            end
                        end
                        d.cnt = CNT_W'(ERASE_CYC);
                    end
                end
                PEND_LOCK: begin
                    d.pend = PEND_NONE;
                    d.mode = MODE_STATUS;
                    if (op == OP_SETLOCK) begin
                        d.locks[blk] = 1'b1;
                        d.cnt        = CNT_W'(LOCK_CYC);
                    end else if (op == OP_CONFIRM) begin
                        d.locks[blk] = 1'b0;
                        d.cnt        = CNT_W'(LOCK_CYC);
                    end else begin
                        d.st[ST_ERASE_ERR] = 1'b1;
                        d.st[ST_PROG_ERR]  = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RESET_S;
        end else begin
            q <= d;
        end
    end

    assign rdata     = q.rd;
    assign busy      = busy_now;
    assign erase_err = q.st[ST_ERASE_ERR];
    assign locks     = q.locks;

endmodule

// File: rtl/nor_pair_model.sv
module nor_pair_model
    import nor_pair_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int BLK_SHIFT = 4,
    parameter int LANES     = 2,
    parameter int PROG_CYC  = 5,
    parameter int ERASE_CYC = 40,
    parameter int LOCK_CYC  = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [LANES*LANE_W-1:0]   bus_wdata,
    input  logic                      bus_we,
    input  logic                      bus_re,
    output logic [LANES*LANE_W-1:0]   bus_rdata
);
    localparam int NBLK = 1 << (ADDR_W - BLK_SHIFT);

    logic [LANES-1:0]           lane_busy;
    logic [LANES-1:0]           lane_erase_err;
    logic [LANES-1:0][NBLK-1:0] lane_locks;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        nor_lane #(
            .ADDR_W    (ADDR_W),
            .BLK_SHIFT (BLK_SHIFT),
            .PROG_CYC  (PROG_CYC),
            .ERASE_CYC (ERASE_CYC),
            .LOCK_CYC  (LOCK_CYC)
        ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .addr      (bus_addr),
            .wdata     (bus_wdata[g*LANE_W +: LANE_W]),
            .we        (bus_we),
            .re        (bus_re),
            .rdata     (bus_rdata[g*LANE_W +: LANE_W]),
            .busy      (lane_busy[g]),
            .erase_err (lane_erase_err[g]),
            .locks     (lane_locks[g])
        );
    end

endmodule

// File: rtl/nor_pair_checker.sv
module nor_pair_checker #(
    parameter int LANES = 2,
    parameter int NBLK  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_we,
    input  logic                       bus_re,
    input  logic [LANES*16-1:0]        bus_rdata,
    input  logic [LANES-1:0]           lane_busy,
    input  logic [LANES-1:0]           lane_erase_err,
    input  logic [LANES-1:0][NBLK-1:0] lane_locks
);
    // R3: read data moves only after a sampled read strobe
    p_rdata_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_re) |-> $stable(bus_rdata));

    for (genvar g = 0; g < LANES; g++) begin : g_chk
        // R8: a busy window opens only at a write edge
        p_busy_on_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(lane_busy[g]) |-> $past(bus_we));

        // R8: a read taken while busy shows ready low
        p_busy_read_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(bus_re) && $past(lane_busy[g])) |-> !bus_rdata[g*16+7]);

        // R9: error flags persist until a write clears them
        p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(lane_erase_err[g]) && !$past(bus_we)) |-> lane_erase_err[g]);

        // R6: lock bits change only through a write
        p_lock_on_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(lane_locks[g]) |-> $past(bus_we));
    end
endmodule

bind nor_pair_model nor_pair_checker #(
    .LANES (LANES),
    .NBLK  (NBLK)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_we         (bus_we),
    .bus_re         (bus_re),
    .bus_rdata      (bus_rdata),
    .lane_busy      (lane_busy),
    .lane_erase_err (lane_erase_err),
    .lane_locks     (lane_locks)
);

// File: tb/tb_nor_pair_model.sv
module tb_nor_pair_model;
    localparam int AW = 6, BS = 4, DEPTH = 64, NBLK = 4;
    localparam int PC = 5, EC = 40, LC = 3;

    logic clk = 0, rst_n = 0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic bus_we = 0, bus_re = 0;
    logic [31:0] bus_rdata;

    int n_chk = 0, n_fail = 0;

    nor_pair_model #(.ADDR_W(AW), .BLK_SHIFT(BS), .LANES(2),
        .PROG_CYC(PC), .ERASE_CYC(EC), .LOCK_CYC(LC)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata));

    always #2 clk = ~clk;

    // reference state
    logic [15:0] rm [2][DEPTH];
    bit          rl [2][NBLK];
    logic [7:0]  rs [2];
    bit          rmode [2];
    int          rpend [2];
    int          rcnt [2];

    function automatic logic [15:0] ref_view(int l, int a);
        if (rmode[l] || rcnt[l] != 0) return {8'h00, rcnt[l] == 0, rs[l][6:0]};
        return rm[l][a];
    endfunction

    task automatic ref_apply(bit we, int a, logic [31:0] wd);
        for (int l = 0; l < 2; l++) begin
            logic [15:0] lw = wd[l*16 +: 16];
            logic [7:0]  b  = lw[7:0];
            int blk = a >> BS;
            if (rcnt[l] > 0) rcnt[l]--;
            else if (we) begin
                case (rpend[l])
                    0: case (b)
                        8'hFF: rmode[l] = 0;
                        8'h70: rmode[l] = 1;
                        8'h50: rs[l] = rs[l] & ~8'h3A;
                        8'h40: rpend[l] = 1;
                        8'h20: rpend[l] = 2;
                        8'h60: rpend[l] = 3;
                        default: ;
                    endcase
                    1: begin
                        rpend[l] = 0; rmode[l] = 1;
                        if (rl[l][blk]) rs[l] = rs[l] | 8'h12;
                        else begin rm[l][a] = rm[l][a] & lw; rcnt[l] = PC; end
                    end
                    2: begin
                        rpend[l] = 0; rmode[l] = 1;
                        if (b != 8'hD0) rs[l] = rs[l] | 8'h30;
                        else if (rl[l][blk]) rs[l] = rs[l] | 8'h22;
                        else begin
                            for (int j = 0; j < DEPTH; j++) if ((j >> BS) == blk) rm[l][j] = 16'hFFFF;
                            rcnt[l] = EC;
                        end
                    end
                    default: begin
                        rpend[l] = 0; rmode[l] = 1;
                        if (b == 8'h01) begin rl[l][blk] = 1; rcnt[l] = LC; end
                        else if (b == 8'hD0) begin rl[l][blk] = 0; rcnt[l] = LC; end
                        else rs[l] = rs[l] | 8'h30;
                    end
                endcase
            end
        end
    endtask

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic bus_cycle(bit we, bit re, int a, logic [31:0] wd, string tag);
        logic [31:0] exp;
        @(negedge clk);
        bus_we = we; bus_re = re; bus_addr = AW'(a); bus_wdata = wd;
        exp = {ref_view(1, a), ref_view(0, a)};
        @(posedge clk);
        ref_apply(we, a, wd);
        #1;
        if (re) chk(bus_rdata == exp, tag, bus_rdata, exp);
    endtask

    function automatic logic [31:0] dup(logic [7:0] c);
        return {8'h00, c, 8'h00, c};
    endfunction

    task automatic wr(int a, logic [31:0] wd, string tag);
        bus_cycle(1, 0, a, wd, tag);
    endtask

    task automatic rd(int a, string tag);
        bus_cycle(0, 1, a, 32'h0, tag);
    endtask

    // R8: count reads that show ready low on both lanes
    task automatic poll_ready(int exp_n, string tag);
        int n = 0;
        for (int k = 0; k < 200; k++) begin
            rd(0, tag);
            if (bus_rdata[7] && bus_rdata[23]) break;
            n++;
        end
        chk(n == exp_n, tag, 32'(n), 32'(exp_n));
    endtask

    bit done = 0;

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        bit [7:0] codes [10] = '{8'hFF, 8'h70, 8'h50, 8'h40, 8'h20, 8'h60, 8'hD0, 8'h01, 8'h90, 8'hE8};
        void'($urandom(32'd1234));
        for (int l = 0; l < 2; l++) begin
            for (int j = 0; j < DEPTH; j++) rm[l][j] = 16'hFFFF;
            for (int b = 0; b < NBLK; b++) rl[l][b] = 0;
            rs[l] = 0; rmode[l] = 0; rpend[l] = 0; rcnt[l] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R1: reset contents and status
        rd(0, "R1 array after reset");
        chk(bus_rdata == 32'hFFFF_FFFF, "R1 erased word", bus_rdata, 32'hFFFF_FFFF);
        rd(63, "R1 last word");
        wr(0, dup(8'h70), "R3");
        rd(0, "R1 status after reset");
        chk(bus_rdata == 32'h0080_0080, "R1 status", bus_rdata, 32'h0080_0080);

        // R4: program with AND semantics, R8 busy count
        wr(5, dup(8'h40), "R4");
        wr(5, 32'h1234_F0F0, "R4");
        poll_ready(PC, "R8 program busy cycles");
        wr(5, dup(8'h40), "R4");
        wr(5, 32'hFF00_0FF0, "R4");
        poll_ready(PC, "R8 program busy cycles");
        wr(0, dup(8'hFF), "R3");
        rd(5, "R4 program result");
        chk(bus_rdata == 32'h1200_00F0, "R4 AND result", bus_rdata, 32'h1200_00F0);

        // R3: read data holds when no read strobe
        bus_cycle(0, 0, 7, 32'h0, "R3 idle");
        chk(bus_rdata == 32'h1200_00F0, "R3 hold", bus_rdata, 32'h1200_00F0);

        // R2: lanes decoded separately, upper byte of a command ignored
        wr(0, 32'h00FF_0070, "R2");
        rd(5, "R2 mixed modes");
        chk(bus_rdata == 32'h1200_0080, "R2 mixed modes", bus_rdata, 32'h1200_0080);
        wr(0, 32'h1270_34FF, "R2");
        rd(5, "R2 upper byte ignored");
        chk(bus_rdata == 32'h0080_00F0, "R2 upper byte ignored", bus_rdata, 32'h0080_00F0);

        // R8: writes during busy ignored
        wr(0, dup(8'hFF), "R3");
        wr(6, dup(8'h40), "R8");
        wr(6, 32'h0000_0000, "R8");
        wr(6, dup(8'hFF), "R8 write while busy");
        poll_ready(PC - 1, "R8 busy window after ignored write");
        rd(6, "R8 still status mode");
        chk(bus_rdata == 32'h0080_0080, "R8 ignored write", bus_rdata, 32'h0080_0080);

        // R6: lock block 1, R7: locked program/erase
        wr(20, dup(8'h60), "R6");
        wr(20, dup(8'h01), "R6");
        poll_ready(LC, "R8 lock busy cycles");
        wr(20, dup(8'h40), "R7");
        wr(20, 32'h0000_0000, "R7");
        rd(20, "R7 locked program status");
        chk(bus_rdata == 32'h0092_0092, "R7 program on locked block", bus_rdata, 32'h0092_0092);
        wr(20, dup(8'h20), "R7");
        wr(20, dup(8'hD0), "R7");
        rd(20, "R7 locked erase status");
        chk(bus_rdata == 32'h00B2_00B2, "R7 erase on locked block", bus_rdata, 32'h00B2_00B2);
        wr(0, dup(8'hFF), "R3");
        rd(20, "R7 array unchanged");
        chk(bus_rdata == 32'hFFFF_FFFF, "R7 array unchanged", bus_rdata, 32'hFFFF_FFFF);

        // R9: clear leaves mode
        wr(0, dup(8'h50), "R9");
        rd(20, "R9 mode kept");
        chk(bus_rdata == 32'hFFFF_FFFF, "R9 mode kept", bus_rdata, 32'hFFFF_FFFF);
        wr(0, dup(8'h70), "R9");
        rd(0, "R9 cleared");
        chk(bus_rdata == 32'h0080_0080, "R9 flags cleared", bus_rdata, 32'h0080_0080);

        // R6 unlock, R5 erase of block 0
        wr(20, dup(8'h60), "R6");
        wr(20, dup(8'hD0), "R6");
        poll_ready(LC, "R6 unlock busy");
        wr(3, dup(8'h20), "R5");
        wr(3, dup(8'hD0), "R5");
        poll_ready(EC, "R8 erase busy cycles");
        wr(0, dup(8'hFF), "R5");
        rd(5, "R5 block erased");
        chk(bus_rdata == 32'hFFFF_FFFF, "R5 erased word", bus_rdata, 32'hFFFF_FFFF);

        // R10: broken sequence
        wr(0, dup(8'h20), "R10");
        wr(0, dup(8'h33), "R10");
        rd(0, "R10 sequence error");
        chk(bus_rdata == 32'h00B0_00B0, "R10 sequence error", bus_rdata, 32'h00B0_00B0);
        wr(0, dup(8'h50), "R9");

        // R11: unsupported codes
        wr(0, dup(8'hFF), "R11");
        wr(0, dup(8'h90), "R11");
        wr(0, dup(8'hE8), "R11");
        rd(5, "R11 array mode kept");
        chk(bus_rdata == 32'hFFFF_FFFF, "R11 array mode kept", bus_rdata, 32'hFFFF_FFFF);
        wr(0, dup(8'h70), "R11");
        wr(0, dup(8'h98), "R11");
        rd(0, "R11 status kept");
        chk(bus_rdata == 32'h0080_0080, "R11 status kept", bus_rdata, 32'h0080_0080);

        // random mix against the reference: R2 R4 R5 R6 R7 R8 R9 R10 R11
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] wd;
            for (int l = 0; l < 2; l++) begin
                if ($urandom % 4 == 0) wd[l*16 +: 16] = 16'($urandom);
                else wd[l*16 +: 16] = {8'($urandom), codes[$urandom % 10]};
            end
            bus_cycle(bit'($urandom % 2), bit'($urandom % 2), int'($urandom % DEPTH), wd,
                      "R2 R4 R5 R6 R7 R8 R9 R10 R11 random");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule